// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a register-programmed watchdog. Software sets a reload value and a control word through a simple memory-mapped register port. While the watchdog runs, a live count steps down from the reload value on a timebase tick. If the count reaches zero, the block raises a reset request output for a programmed number of system clocks. It also latches a sticky timeout flag and then stops counting.

The only way to restart the countdown is to write a 16-bit key into the restart register. The watchdog starts only when the enable bit goes from 0 to 1 and stops only when it goes from 1 to 0. The timebase tick comes from a prescaler that divides the system clock down to 1 MHz. The `SELECTABLE` parameter picks one of two variants. In the selectable variant, control bit 4 chooses between the divided tick and the raw bus clock, and the pulse-width field is 8 bits. In the fixed variant, the tick is always the divided one, bit 4 always reads 1, and the pulse-width field is 20 bits.

Register offsets: 0x00 live count (read-only), 0x04 reload value, 0x08 restart, 0x0C control (bit 0 enable, bit 4 tick select), 0x10 timeout status (bit 0), 0x14 reset pulse width.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the count, reload, timeout status and pulse-width registers read 0, and the reset output is low. Control reads 0x0 in the selectable variant and 0x10 in the fixed variant.
- R2: A write to 0x08 whose low 16 bits equal `RESTART_KEY` (default 16'h4755) loads the live count from the reload register, whatever the upper 16 bits hold. Any other write to 0x08 leaves the count unchanged.
- R3: A valid restart made while control bit 0 is 0 loads the count, but the count then holds its value.
- R4: A control write with bit 0 set, made while the stored bit 0 is 0, stores the word, loads the count from reload and starts counting down.
- R5: A control write with bit 0 clear, made while the stored bit 0 is 1, stores the word, and the count holds from that edge on.
- R6: With the tick from the prescaler, the count drops once every `CLK_DIV` clocks. In the selectable variant with bit 4 = 0, it drops once per clock. The reset output rises reload×`CLK_DIV`+1 clocks after the starting write edge (reload+1 clocks on the raw clock).
- R7: In the fixed variant, control bit 4 always reads 1, writes to it are ignored, and the prescaled tick is always used.
- R8: On expiry, the reset output stays high for exactly the programmed pulse width in clocks, and status bit 0 reads 1. The count stays at 0, and no further pulse follows.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set.
- R10: The pulse-width register keeps its low 8 bits in the selectable variant and its low 20 bits in the fixed variant. Higher bits read 0.
- R11: Reads of unmapped offsets return 0, and writes to 0x00 do not change the count.
- R12: A valid restart sampled in the same cycle that expiry would fire wins. No pulse is produced, the flag stays clear, and the countdown runs again from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational on busAddr |
| wdResetOut | output | 1 | Reset request pulse on expiry |

## Verification
Two functions can fall on the same clock edge: expiry, when a running count sits at zero, and a keyed restart. The bench uses the raw-clock tick with a reload of 3. It places the restart write exactly on the edge where expiry would fire, counting the edges from the enabling write. It then judges that no reset pulse appears and the status flag stays 0. A fresh timeout must also arrive exactly reload+1 clocks after the restart, which shows that the count was reloaded rather than expired.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_RELOAD  = 'h04;
  localparam int OFS_RESTART = 'h08;
  localparam int OFS_CTRL    = 'h0C;
  localparam int OFS_STATUS  = 'h10;
  localparam int OFS_PULSE   = 'h14;
  localparam int EN_BIT      = 0;
  localparam int SEL_BIT     = 4;

  typedef struct packed {
    logic load;
    logic run;
    logic halt;
    logic clrFlag;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int PULSE_W = 8,
  parameter logic [15:0] RESTART_KEY = 16'h4755,
  parameter bit SELECTABLE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] liveCount,
  input  logic timeoutFlag,
  output wdStrobe_t strb,
  output logic [DATA_W-1:0] reloadVal,
  output logic [PULSE_W-1:0] pulseWidth,
  output logic fastTick
);
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << SEL_BIT;
  localparam logic [DATA_W-1:0] CTRL_RST = SELECTABLE ? '0 : SEL_MASK;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] ctrlNext;
  logic wrEn, enBit, keyHit;
  logic hitReload, hitRestart, hitCtrl, hitStatus, hitPulse;

  assign wrEn       = busSel && busWr;
  assign enBit      = ctrlReg[EN_BIT];
  assign keyHit     = busWdata[15:0] == RESTART_KEY;
  assign hitReload  = busAddr == ADDR_W'(OFS_RELOAD);
  assign hitRestart = busAddr == ADDR_W'(OFS_RESTART);
  assign hitCtrl    = busAddr == ADDR_W'(OFS_CTRL);
  assign hitStatus  = busAddr == ADDR_W'(OFS_STATUS);
  assign hitPulse   = busAddr == ADDR_W'(OFS_PULSE);

  generate
    if (SELECTABLE) begin : g_liveSel
      assign ctrlNext = busWdata;
      assign fastTick = !ctrlReg[SEL_BIT];
    end else begin : g_fixedSel
      assign ctrlNext = busWdata | SEL_MASK;
      assign fastTick = 1'b0;
    end
  endgenerate

  always_comb begin
    strb = '0;
    if (wrEn && hitRestart && keyHit) begin
      strb.load = 1'b1;
      strb.run  = enBit;
    end
    if (wrEn && hitCtrl) begin
      if (busWdata[EN_BIT] && !enBit) begin
        strb.load = 1'b1;
        strb.run  = 1'b1;
      end else if (!busWdata[EN_BIT] && enBit) begin
        strb.halt = 1'b1;
      end
    end
    if (wrEn && hitStatus && busWdata[0]) strb.clrFlag = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= CTRL_RST;
      reloadVal  <= '0;
      pulseWidth <= '0;
    end else if (wrEn) begin
      if (hitCtrl)   ctrlReg    <= ctrlNext;
      if (hitReload) reloadVal  <= busWdata;
      if (hitPulse)  pulseWidth <= busWdata[PULSE_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_COUNT):  busRdata = liveCount;
      ADDR_W'(OFS_RELOAD): busRdata = reloadVal;
      ADDR_W'(OFS_CTRL):   busRdata = ctrlReg;
      ADDR_W'(OFS_STATUS): busRdata = DATA_W'(timeoutFlag);
      ADDR_W'(OFS_PULSE):  busRdata = DATA_W'(pulseWidth);
      default:             busRdata = '0;
    endcase
  end

  // R2: a restart write without the key never reloads the count
  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitRestart && !keyHit) |-> !strb.load);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PULSE_W = 8,
  parameter int CLK_DIV = 50
) (
  input  logic clk,
  input  logic rstN,
  input  wdStrobe_t strb,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic [PULSE_W-1:0] pulseWidth,
  input  logic fastTick,
  output logic [DATA_W-1:0] liveCount,
  output logic timeoutFlag,
  output logic resetOut
);
  localparam int PRESC_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_TOP = PRESC_W'(CLK_DIV - 1);

  logic [PRESC_W-1:0] presc;
  logic [PULSE_W-1:0] pulseCnt;
  logic running, tick, expire, prescWrap;

  assign prescWrap = presc == PRESC_TOP;
  assign tick      = running && (fastTick || prescWrap);
  assign expire    = running && (liveCount == '0) && !strb.load;
  assign resetOut  = pulseCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc       <= '0;
      liveCount   <= '0;
      running     <= 1'b0;
      timeoutFlag <= 1'b0;
      pulseCnt    <= '0;
    end else begin
      if (strb.load || prescWrap) presc <= '0;
      else                        presc <= presc + 1'b1;

      if (strb.load)                     liveCount <= reloadVal;
      else if (tick && liveCount != '0)  liveCount <= liveCount - 1'b1;

      if (strb.halt)     running <= 1'b0;
      else if (strb.run) running <= 1'b1;
      else if (expire)   running <= 1'b0;

      if (expire)            timeoutFlag <= 1'b1;
      else if (strb.clrFlag) timeoutFlag <= 1'b0;

      if (expire)               pulseCnt <= pulseWidth;
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R2: a reload strobe puts the reload value into the count
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> liveCount == $past(reloadVal));
  // R5: a stopped watchdog keeps its count
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.load) |=> $stable(liveCount));
  // R5: halting clears the running state
  assert_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> !running);
  // R9: the timeout flag is sticky until cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !strb.clrFlag) |=> timeoutFlag);
  // R8: a pulse starts only together with a latched timeout and a stop
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOut) |-> (timeoutFlag && !running));
  // R12: a reload in the expiry cycle suppresses the pulse
  assert_restart_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !$rose(resetOut));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CLK_DIV = 50,
  parameter logic [15:0] RESTART_KEY = 16'h4755,
  parameter bit SELECTABLE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic wdResetOut
);
  localparam int PULSE_W = SELECTABLE ? 8 : 20;

  wdStrobe_t strb;
  logic [DATA_W-1:0] reloadVal, liveCount;
  logic [PULSE_W-1:0] pulseWidth;
  logic fastTick, timeoutFlag;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_W(PULSE_W),
    .RESTART_KEY(RESTART_KEY), .SELECTABLE(SELECTABLE)
  ) uRegs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .liveCount(liveCount), .timeoutFlag(timeoutFlag), .strb(strb),
    .reloadVal(reloadVal), .pulseWidth(pulseWidth), .fastTick(fastTick)
  );

  wdog_core #(
    .DATA_W(DATA_W), .PULSE_W(PULSE_W), .CLK_DIV(CLK_DIV)
  ) uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .pulseWidth(pulseWidth), .fastTick(fastTick), .liveCount(liveCount),
    .timeoutFlag(timeoutFlag), .resetOut(wdResetOut)
  );
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selA = 1'b0, selB = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdA, rdB;
  logic rstOutA, rstOutB;
  int checks = 0, errors = 0;

  logic [31:0] expQ[$];
  string tagQ[$];
  bit whichQ[$];
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.CLK_DIV(DIV), .SELECTABLE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .busSel(selA), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdA), .wdResetOut(rstOutA));

  keyed_watchdog #(.CLK_DIV(DIV), .SELECTABLE(1'b0)) dutFixed (
    .clk(clk), .rstN(rstN), .busSel(selB), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdB), .wdResetOut(rstOutB));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the selected port
  always @(sampleEv) begin
    logic [31:0] e;
    logic [31:0] a;
    string t;
    bit w;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    w = whichQ.pop_front();
    a = w ? rdB : rdA;
    check(a == e, t, a, e);
  end

  task automatic wr(input bit which, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    selA = !which; selB = which; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    selA = 1'b0; selB = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input bit which, input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a;
    expQ.push_back(e); tagQ.push_back(tag); whichQ.push_back(which);
    #1 ->sampleEv;
    #1;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic waitPulse(input bit which, input int expN, input int expW, input string tag);
    int n = 0;
    int m = 0;
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(posedge clk); #1; n++;
      if (which ? rstOutB : rstOutA) seen = 1;
    end
    check(seen && n == expN, {tag, " rise delay"}, n, expN);
    while (seen && (which ? rstOutB : rstOutA) && m < 100) begin
      m++;
      @(posedge clk); #1;
    end
    if (expW >= 0) check(m == expW, {tag, " pulse width"}, m, expW);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(rstOutA == 1'b0, "R1 reset output", rstOutA, 0);
    rd(0, 8'h00, 0, "R1 count");
    rd(0, 8'h04, 0, "R1 reload");
    rd(0, 8'h0C, 0, "R1 ctrl");
    rd(0, 8'h10, 0, "R1 status");
    rd(0, 8'h14, 0, "R1 pulse");
    rd(1, 8'h0C, 32'h10, "R1 R7 fixed ctrl");
    // R10 pulse width masking
    wr(0, 8'h14, 32'hFFFF_FF03);
    rd(0, 8'h14, 32'h03, "R10 width 8");
    wr(1, 8'h14, 32'hFFFF_FFFF);
    rd(1, 8'h14, 32'h000F_FFFF, "R10 width 20");
    // R2 key handling
    wr(0, 8'h04, 32'd4);
    rd(0, 8'h04, 32'd4, "R2 reload readback");
    wr(0, 8'h08, 32'h0000_ABCD);
    rd(0, 8'h00, 0, "R2 bad key ignored");
    wr(0, 8'h08, 32'hDEAD_4755);
    rd(0, 8'h00, 32'd4, "R2 key restart");
    // R3 disabled restart holds
    idle(20);
    rd(0, 8'h00, 32'd4, "R3 disabled holds");
    // R4 R6 slow tick start
    wr(0, 8'h0C, 32'h11);
    waitPulse(0, 4*DIV+1, 3, "R4 R6 R8 slow");
    rd(0, 8'h10, 1, "R8 flag set");
    rd(0, 8'h00, 0, "R8 count zero");
    idle(20);
    check(rstOutA == 1'b0, "R8 no second pulse", rstOutA, 0);
    // R9 flag clear
    wr(0, 8'h10, 0);
    rd(0, 8'h10, 1, "R9 write 0 keeps");
    wr(0, 8'h10, 1);
    rd(0, 8'h10, 0, "R9 write 1 clears");
    // R6 fast tick
    wr(0, 8'h0C, 32'h10);
    wr(0, 8'h0C, 32'h01);
    waitPulse(0, 4+1, 3, "R6 fast");
    wr(0, 8'h10, 1);
    // R5 stop holds count
    wr(0, 8'h0C, 32'h0);
    wr(0, 8'h04, 32'd100);
    wr(0, 8'h0C, 32'h11);
    idle(10);
    wr(0, 8'h0C, 32'h10);
    idle(30);
    rd(0, 8'h00, 32'd98, "R5 stopped count");
    // R11 unmapped and read-only count
    rd(0, 8'h18, 0, "R11 unmapped 18");
    rd(0, 8'h1C, 0, "R11 unmapped 1C");
    wr(0, 8'h00, 32'h55);
    rd(0, 8'h00, 32'd98, "R11 count write ignored");
    // R12 restart in the expiry cycle
    wr(0, 8'h0C, 32'h0);
    wr(0, 8'h04, 32'd3);
    wr(0, 8'h0C, 32'h01);
    idle(2);
    wr(0, 8'h08, 32'h0000_4755);
    check(rstOutA == 1'b0, "R12 no pulse on collision", rstOutA, 0);
    rd(0, 8'h10, 0, "R12 flag clear");
    waitPulse(0, 3, 3, "R12 rerun");
    wr(0, 8'h0C, 32'h0);
    // R7 fixed variant
    wr(1, 8'h0C, 32'h0);
    rd(1, 8'h0C, 32'h10, "R7 bit4 sticks");
    wr(1, 8'h14, 32'd2);
    wr(1, 8'h04, 32'd2);
    wr(1, 8'h0C, 32'h01);
    rd(1, 8'h0C, 32'h11, "R7 ctrl readback");
    waitPulse(1, 2*DIV+1-1, 2, "R7 fixed tick");
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule